// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block acts as the host end of a two-wire serial debug link. It runs single register reads and writes over a clock pin and a bidirectional data pin, and two housekeeping line sequences: the switch from scan-chain protocol to the serial wire protocol, and an idle flush. The user side takes one command at a time. A command is an 8-bit request byte, which carries the access-port/debug-port select, the read/write flag and the address bits, plus 32 bits of write data. The block answers with read data, the received 3-bit acknowledge and failure flags.

The user side is a valid/ready pair in each direction. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from that edge until the response has been taken. The response is offered with `rsp_valid` and is held unchanged for as long as `rsp_ready` is low, so the next command waits while the response is back-pressured. The `cfg_*` inputs are captured when a command is accepted.

Failures are sticky. After a bad acknowledge or a read parity mismatch, every transfer and switch command is refused without touching the pins, until a flush command reports the recorded failure and clears it. After a successful access-port access the block adds a programmable number of idle clocks.

Top module: `swd_host`

## Requirements
- R1: SWCLK idles low. Each SWCLK half period lasts `cfg_clk_div`+1 system clocks. The host changes SWDIO only while SWCLK is low, and it samples `swdio_in` at the end of the low half. Every field is sent least significant bit first.
- R2: A transfer (`cmd_op`=0) first drives the 8 bits of `cmd_req`, with bit 0 (start) and bit 7 (park) forced to 1. Bit 1 selects an access-port access and bit 2 selects a read.
- R3: After the request the host releases SWDIO (`swdio_oe`=0) for T=`cfg_turn`+1 turnaround cycles, then samples a 3-bit acknowledge. The value OK is 3'b001, meaning the first received bit is 1 and the next two are 0.
- R4: On a read with acknowledge OK, the host samples 32 data bits and 1 parity bit, releases the line for T more cycles, and returns the data on `rsp_rdata` with `rsp_fail`=0.
- R5: On a write, the line stays released for T cycles, the acknowledge and T more cycles. With acknowledge OK the host then drives the 32 data bits and a parity bit equal to the XOR of the data.
- R6: Any acknowledge other than 3'b001 (WAIT, FAULT or an undefined value) ends the transfer after T released cycles with no data phase. The block sets `rsp_fail`=1, reports the value on `rsp_ack` and records it as a sticky failure.
- R7: On a read, a parity bit that does not equal the XOR of the 32 data bits sets `rsp_fail`=1 and `rsp_parity_err`=1, returns `rsp_rdata`=0 and records a sticky failure. No idle clocks follow.
- R8: While a sticky failure is recorded, transfer and switch commands run no SWCLK cycles. Each is answered with `rsp_blocked`=1 and `rsp_fail`=1.
- R9: A flush (`cmd_op`=2 or 3) drives 8 SWCLK cycles with SWDIO low. It reports the sticky state on `rsp_fail`, the recorded acknowledge on `rsp_ack` (0 if none) and a recorded parity failure on `rsp_parity_err`, then clears all three. A flush always runs.
- R10: After a successful access-port transfer, the host adds `cfg_ap_idle` SWCLK cycles with SWDIO driven low. Debug-port transfers and failed transfers add none.
- R11: A switch (`cmd_op`=1) drives 56 cycles high, then 16'hE79E least significant bit first, then 52 cycles high, then 4 cycles low, for 128 cycles in total.
- R12: After reset `cmd_ready`=1, `rsp_valid`=0, SWCLK=0 and SWDIO is driven low. `cmd_ready` and `rsp_valid` are never high together. A response that is not taken stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk_div | input | DIV_W | SWCLK half period minus one, in system clocks |
| cfg_turn | input | 2 | Turnaround length minus one |
| cfg_ap_idle | input | IDLE_W | Idle clocks after a successful access-port transfer |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | 0 transfer, 1 switch, 2 or 3 flush |
| cmd_req | input | 8 | Request byte |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data, zero unless a read succeeded |
| rsp_ack | output | 3 | Received or recorded acknowledge |
| rsp_fail | output | 1 | Command failed, was refused, or flush found a failure |
| rsp_parity_err | output | 1 | Read parity mismatch |
| rsp_blocked | output | 1 | Command refused because of a sticky failure |
| swclk | output | 1 | Serial clock |
| swdio_out | output | 1 | Serial data driven by the host |
| swdio_oe | output | 1 | Host drives serial data when high |
| swdio_in | input | 1 | Serial data from the line |

## Verification
The checker watches the properties that must hold on every cycle. SWDIO and its enable stay still through each high half of SWCLK. The clock stays low while a command can be taken. The two handshake sides never overlap, and a held response does not change. A parity or refusal response never carries data. Only the bench scenarios show the whole frame: the forced request bits, the released windows, the data and parity bits, the idle count, the switch pattern, and the sticky failure running from the failing transfer through refused commands to the flush that clears it. The bench plays the target at bit level and decodes every SWCLK cycle to check these.

// File: rtl/swd_host_pkg.sv
`timescale 1ns/1ps
package swd_host_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    OP_XFER   = 2'd0,
    OP_SWITCH = 2'd1,
    OP_FLUSH  = 2'd2,
    OP_FLUSH2 = 2'd3
  } swd_op_e;

  localparam logic [2:0] ACK_GOOD = 3'b001;

  // line sequence lengths
  localparam int unsigned REQ_BITS   = 8;
  localparam int unsigned ACK_BITS   = 3;
  localparam int unsigned FLUSH_BITS = 8;
  localparam int unsigned SW_HI_A    = 56;
  localparam int unsigned SW_PAT_LEN = 16;
  localparam int unsigned SW_HI_B    = 52;
  localparam int unsigned SW_LO_LEN  = 4;
  localparam logic [15:0] SW_PATTERN = 16'hE79E;
  localparam logic [7:0]  REQ_FORCE  = 8'h81;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_TRN1,
    ST_ACK,
    ST_RDATA,
    ST_TRN2,
    ST_WDATA,
    ST_APIDLE,
    ST_FLUSH,
    ST_SWHI1,
    ST_SWPAT,
    ST_SWHI2,
    ST_SWLO,
    ST_RESP
  } seq_st_e;

endpackage

// File: rtl/swd_clk_gen.sv
`timescale 1ns/1ps
// Half-period tick generator; divider captured while the line is quiet.
module swd_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (!run) begin
      div_q <= div;
      cnt_q <= '0;
    end else if (cnt_q == div_q) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == div_q);
endmodule

// File: rtl/swd_pin_phy.sv
`timescale 1ns/1ps
// Produces SWCLK and the per-bit strobes: sample at end of low half,
// bit boundary at end of high half.
module swd_pin_phy (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic swclk,
  output logic sample_stb,
  output logic bit_end
);
  logic high_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_half <= 1'b0;
      swclk     <= 1'b0;
    end else if (!run) begin
      high_half <= 1'b0;
      swclk     <= 1'b0;
    end else if (tick) begin
      high_half <= ~high_half;
      swclk     <= ~high_half;
    end
  end

  assign sample_stb = tick && !high_half;
  assign bit_end    = tick && high_half;
endmodule

// File: rtl/swd_seq.sv
`timescale 1ns/1ps
module swd_seq
  import swd_host_pkg::*;
#(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_turn,
  input  logic [IDLE_W-1:0] cfg_ap_idle,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_req,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [2:0]        rsp_ack,
  output logic              rsp_fail,
  output logic              rsp_parity_err,
  output logic              rsp_blocked,
  output logic              run,
  input  logic              sample_stb,
  input  logic              bit_end,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int CNT_W = (IDLE_W > 6) ? IDLE_W : 6;
  localparam int SH_W  = WORD_W + 1;

  seq_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-1:0]   tx_sh;
  logic [SH_W-1:0]   rx_sh;
  logic [2:0]        ack_sh;
  logic [1:0]        trn_l;
  logic [IDLE_W-1:0] idle_l;
  logic [WORD_W-1:0] wdata_l;
  logic              is_read, is_ap, failed, par_bad;
  logic              err_flag, err_par;
  logic [2:0]        err_ack;
  logic              want_idle;
  logic              rx_par_ok;

  assign want_idle = is_ap && (idle_l != '0);
  assign rx_par_ok = (^rx_sh[WORD_W-1:0]) == rx_sh[WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= ST_IDLE;
      cnt            <= '0;
      tx_sh          <= '0;
      rx_sh          <= '0;
      ack_sh         <= '0;
      trn_l          <= '0;
      idle_l         <= '0;
      wdata_l        <= '0;
      is_read        <= 1'b0;
      is_ap          <= 1'b0;
      failed         <= 1'b0;
      par_bad        <= 1'b0;
      err_flag       <= 1'b0;
      err_par        <= 1'b0;
      err_ack        <= '0;
      rsp_rdata      <= '0;
      rsp_ack        <= '0;
      rsp_fail       <= 1'b0;
      rsp_parity_err <= 1'b0;
      rsp_blocked    <= 1'b0;
    end else begin
      if (sample_stb && st == ST_ACK)   ack_sh <= {sdi, ack_sh[2:1]};
      if (sample_stb && st == ST_RDATA) rx_sh  <= {sdi, rx_sh[SH_W-1:1]};

      case (st)
        ST_IDLE: begin
          if (cmd_valid) begin
            trn_l          <= cfg_turn;
            idle_l         <= cfg_ap_idle;
            wdata_l        <= cmd_wdata;
            is_read        <= cmd_req[2];
            is_ap          <= cmd_req[1];
            failed         <= 1'b0;
            par_bad        <= 1'b0;
            rsp_rdata      <= '0;
            rsp_ack        <= '0;
            rsp_fail       <= 1'b0;
            rsp_parity_err <= 1'b0;
            rsp_blocked    <= 1'b0;
            case (cmd_op)
              OP_XFER, OP_SWITCH: begin
                if (err_flag) begin
                  rsp_blocked <= 1'b1;
                  rsp_fail    <= 1'b1;
                  st          <= ST_RESP;
                end else if (cmd_op == OP_XFER) begin
                  tx_sh <= SH_W'(cmd_req | REQ_FORCE);
                  cnt   <= CNT_W'(REQ_BITS - 1);
                  st    <= ST_REQ;
                end else begin
                  tx_sh <= '0;
                  cnt   <= CNT_W'(SW_HI_A - 1);
                  st    <= ST_SWHI1;
                end
              end
              default: begin
                tx_sh <= '0;
                cnt   <= CNT_W'(FLUSH_BITS - 1);
                st    <= ST_FLUSH;
              end
            endcase
          end
        end

        ST_RESP: begin
          if (rsp_ready) st <= ST_IDLE;
        end

        default: begin
          if (bit_end) begin
            if (cnt != '0) begin
              cnt   <= cnt - 1'b1;
              tx_sh <= {1'b0, tx_sh[SH_W-1:1]};
            end else begin
              case (st)
                ST_REQ: begin
                  cnt <= CNT_W'(trn_l);
                  st  <= ST_TRN1;
                end
                ST_TRN1: begin
                  cnt <= CNT_W'(ACK_BITS - 1);
                  st  <= ST_ACK;
                end
                ST_ACK: begin
                  if (ack_sh == ACK_GOOD && is_read) begin
                    cnt <= CNT_W'(SH_W - 1);
                    st  <= ST_RDATA;
                  end else begin
                    if (ack_sh != ACK_GOOD) begin
                      failed   <= 1'b1;
                      err_flag <= 1'b1;
                      err_ack  <= ack_sh;
                    end
                    cnt <= CNT_W'(trn_l);
                    st  <= ST_TRN2;
                  end
                end
                ST_RDATA: begin
                  if (!rx_par_ok) begin
                    failed   <= 1'b1;
                    par_bad  <= 1'b1;
                    err_flag <= 1'b1;
                    err_par  <= 1'b1;
                  end
                  cnt <= CNT_W'(trn_l);
                  st  <= ST_TRN2;
                end
                ST_TRN2: begin
                  if (!failed && !is_read) begin
                    tx_sh <= {^wdata_l, wdata_l};
                    cnt   <= CNT_W'(SH_W - 1);
                    st    <= ST_WDATA;
                  end else if (!failed && want_idle) begin
                    tx_sh <= '0;
                    cnt   <= CNT_W'(idle_l - 1'b1);
                    st    <= ST_APIDLE;
                  end else begin
                    rsp_ack        <= ack_sh;
                    rsp_fail       <= failed;
                    rsp_parity_err <= par_bad;
                    rsp_rdata      <= (is_read && !failed) ? rx_sh[WORD_W-1:0] : '0;
                    st             <= ST_RESP;
                  end
                end
                ST_WDATA: begin
                  if (want_idle) begin
                    tx_sh <= '0;
                    cnt   <= CNT_W'(idle_l - 1'b1);
                    st    <= ST_APIDLE;
                  end else begin
                    rsp_ack <= ack_sh;
                    st      <= ST_RESP;
                  end
                end
                ST_APIDLE: begin
                  rsp_ack   <= ack_sh;
                  rsp_rdata <= is_read ? rx_sh[WORD_W-1:0] : '0;
                  st        <= ST_RESP;
                end
                ST_FLUSH: begin
                  rsp_fail       <= err_flag;
                  rsp_ack        <= err_ack;
                  rsp_parity_err <= err_par;
                  err_flag       <= 1'b0;
                  err_ack        <= '0;
                  err_par        <= 1'b0;
                  st             <= ST_RESP;
                end
                ST_SWHI1: begin
                  tx_sh <= SH_W'(SW_PATTERN);
                  cnt   <= CNT_W'(SW_PAT_LEN - 1);
                  st    <= ST_SWPAT;
                end
                ST_SWPAT: begin
                  tx_sh <= '0;
                  cnt   <= CNT_W'(SW_HI_B - 1);
                  st    <= ST_SWHI2;
                end
                ST_SWHI2: begin
                  cnt <= CNT_W'(SW_LO_LEN - 1);
                  st  <= ST_SWLO;
                end
                default: begin
                  st <= ST_RESP;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    sdo_en = 1'b1;
    sdo    = 1'b0;
    case (st)
      ST_TRN1, ST_ACK, ST_RDATA, ST_TRN2: sdo_en = 1'b0;
      ST_REQ, ST_WDATA, ST_SWPAT:         sdo    = tx_sh[0];
      ST_SWHI1, ST_SWHI2:                 sdo    = 1'b1;
      default:                            sdo    = 1'b0;
    endcase
  end

  assign cmd_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign run       = (st != ST_IDLE) && (st != ST_RESP);
endmodule

// File: rtl/swd_host.sv
`timescale 1ns/1ps
module swd_host
  import swd_host_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_clk_div,
  input  logic [1:0]        cfg_turn,
  input  logic [IDLE_W-1:0] cfg_ap_idle,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [7:0]        cmd_req,
  input  logic [31:0]       cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic [2:0]        rsp_ack,
  output logic              rsp_fail,
  output logic              rsp_parity_err,
  output logic              rsp_blocked,
  output logic              swclk,
  output logic              swdio_out,
  output logic              swdio_oe,
  input  logic              swdio_in
);
  logic run, tick, sample_stb, bit_end;

  swd_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .div  (cfg_clk_div),
    .tick (tick)
  );

  swd_pin_phy u_phy (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .tick      (tick),
    .swclk     (swclk),
    .sample_stb(sample_stb),
    .bit_end   (bit_end)
  );

  swd_seq #(.IDLE_W(IDLE_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_turn      (cfg_turn),
    .cfg_ap_idle   (cfg_ap_idle),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cmd_req       (cmd_req),
    .cmd_wdata     (cmd_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_rdata     (rsp_rdata),
    .rsp_ack       (rsp_ack),
    .rsp_fail      (rsp_fail),
    .rsp_parity_err(rsp_parity_err),
    .rsp_blocked   (rsp_blocked),
    .run           (run),
    .sample_stb    (sample_stb),
    .bit_end       (bit_end),
    .sdi           (swdio_in),
    .sdo           (swdio_out),
    .sdo_en        (swdio_oe)
  );
endmodule

// File: rtl/swd_host_chk.sv
`timescale 1ns/1ps
module swd_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic [2:0]  rsp_ack,
  input logic        rsp_fail,
  input logic        rsp_parity_err,
  input logic        rsp_blocked,
  input logic        swclk,
  input logic        swdio_out,
  input logic        swdio_oe
);
  assert_data_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && $past(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe)));

  assert_clk_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !swclk);

  assert_hs_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && rsp_valid));

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) &&
      $stable(rsp_ack) && $stable(rsp_fail) && $stable(rsp_blocked)));

  assert_parity_nodata_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_parity_err) |-> (rsp_fail && rsp_rdata == 32'h0));

  assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_blocked) |-> (rsp_fail && rsp_rdata == 32'h0));

  assert_line_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!swclk && swdio_oe && !swdio_out));
endmodule

bind swd_host swd_host_chk u_swd_host_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_rdata     (rsp_rdata),
  .rsp_ack       (rsp_ack),
  .rsp_fail      (rsp_fail),
  .rsp_parity_err(rsp_parity_err),
  .rsp_blocked   (rsp_blocked),
  .swclk         (swclk),
  .swdio_out     (swdio_out),
  .swdio_oe      (swdio_oe)
);

// File: tb/swd_host_tb_top.sv
`timescale 1ns/1ps
module swd_host_tb_top;
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  req;
    logic [31:0] wdata;
    logic [1:0]  trn;
    logic [7:0]  idle;
    logic [2:0]  tack;
    logic [31:0] trd;
    logic        badpar;
  } vec_t;

  localparam int MAXB = 160;
  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 8'h24, 32'h0,        2'd0, 8'd4, 3'b001, 32'h2BA01477, 1'b0}, // DP read
    '{2'd0, 8'h0A, 32'hDEADBEEF, 2'd1, 8'd3, 3'b001, 32'h0,        1'b0}, // AP write
    '{2'd0, 8'h9F, 32'h0,        2'd3, 8'd5, 3'b001, 32'h12345678, 1'b0}, // AP read T=4
    '{2'd0, 8'h31, 32'h00000001, 2'd0, 8'd7, 3'b001, 32'h0,        1'b0}, // DP write
    '{2'd0, 8'h87, 32'h0,        2'd2, 8'd0, 3'b001, 32'hFFFFFFFF, 1'b0}, // AP read no idle
    '{2'd1, 8'h00, 32'h0,        2'd0, 8'd0, 3'b000, 32'h0,        1'b0}, // switch
    '{2'd2, 8'h00, 32'h0,        2'd0, 8'd0, 3'b000, 32'h0,        1'b0}  // clean flush
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  cfg_clk_div = 8'd1;
  logic [1:0]  cfg_turn = '0;
  logic [7:0]  cfg_ap_idle = '0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [7:0]  cmd_req = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [2:0]  rsp_ack;
  logic        rsp_fail, rsp_parity_err, rsp_blocked;
  logic        swclk, swdio_out, swdio_oe;
  logic        swdio_in;

  swd_host #(.DIV_W(8), .IDLE_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_clk_div(cfg_clk_div), .cfg_turn(cfg_turn),
    .cfg_ap_idle(cfg_ap_idle), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_req(cmd_req), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_ack(rsp_ack), .rsp_fail(rsp_fail), .rsp_parity_err(rsp_parity_err),
    .rsp_blocked(rsp_blocked), .swclk(swclk), .swdio_out(swdio_out),
    .swdio_oe(swdio_oe), .swdio_in(swdio_in)
  );

  // bit-level target model
  logic    tgt [MAXB];
  logic    hb  [MAXB];
  logic    ho  [MAXB];
  int      nrise = 0, nfall = 0, base = 0;
  realtime t_rise = 0, hi_w = 0;

  always @(posedge swclk) begin
    int k;
    k = nrise - base;
    if (k >= 0 && k < MAXB) begin
      hb[k] = swdio_out;
      ho[k] = swdio_oe;
    end
    nrise = nrise + 1;
    t_rise = $realtime;
  end

  always @(negedge swclk) begin
    nfall = nfall + 1;
    hi_w = $realtime - t_rise;
  end

  always @* begin
    if ((nfall - base) >= 0 && (nfall - base) < MAXB) swdio_in = tgt[nfall - base];
    else swdio_in = 1'b0;
  end

  int n_checks = 0, n_err = 0;
  logic        m_err = 1'b0, m_par = 1'b0;
  logic [2:0]  m_ack = '0;
  logic [31:0] r_rdata;
  logic [2:0]  r_ack;
  logic        r_fail, r_par, r_blk;
  int          nb;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input vec_t v);
    int t;
    t = int'(v.trn) + 1;
    for (int i = 0; i < MAXB; i++) tgt[i] = 1'b0;
    for (int i = 0; i < MAXB; i++) begin hb[i] = 1'b0; ho[i] = 1'b1; end
    for (int j = 0; j < 3; j++) tgt[8 + t + j] = v.tack[j];
    if (v.req[2]) begin
      for (int j = 0; j < 32; j++) tgt[11 + t + j] = v.trd[j];
      tgt[43 + t] = (^v.trd) ^ v.badpar;
    end
    base = nrise;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = v.op; cmd_req = v.req; cmd_wdata = v.wdata;
    cfg_turn = v.trn; cfg_ap_idle = v.idle;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_rdata = rsp_rdata; r_ack = rsp_ack; r_fail = rsp_fail;
    r_par = rsp_parity_err; r_blk = rsp_blocked;
    nb = nrise - base;
    @(negedge clk);
  endtask

  // runs a command and checks it against the bench's own model
  task automatic do_vec(input vec_t v, input string tag);
    int t, eb, bad, p;
    logic rd, ap, ackok, blk, ef, ep;
    logic [2:0] ea;
    logic [31:0] ed;
    t = int'(v.trn) + 1;
    rd = v.req[2]; ap = v.req[1];
    blk = m_err && (v.op < 2);
    ackok = (v.tack == 3'b001);
    ef = 1'b0; ep = 1'b0; ea = 3'b000; ed = '0; eb = 0;
    if (v.op >= 2) begin
      ef = m_err; ea = m_ack; ep = m_par; eb = 8;
      m_err = 1'b0; m_ack = '0; m_par = 1'b0;
    end else if (blk) begin
      ef = 1'b1;
    end else if (v.op == 1) begin
      eb = 128;
    end else begin
      ea = v.tack;
      ep = ackok && rd && v.badpar;
      ef = !ackok || ep;
      ed = (rd && !ef) ? v.trd : '0;
      eb = 11 + t;
      if (!ackok) eb += t;
      else if (rd) eb += 33 + t + ((!ep && ap) ? int'(v.idle) : 0);
      else eb += t + 33 + (ap ? int'(v.idle) : 0);
      if (ef) begin
        m_err = 1'b1;
        if (!ackok) m_ack = v.tack;
        if (ep) m_par = 1'b1;
      end
    end
    run_cmd(v);
    $display("  %s", tag);
    check(r_fail == ef,  "R6/R7 rsp_fail", 64'(r_fail), 64'(ef));
    check(r_blk  == blk, "R8 rsp_blocked", 64'(r_blk), 64'(blk));
    check(r_par  == ep,  "R7 rsp_parity_err", 64'(r_par), 64'(ep));
    check(r_ack  == ea,  "R9 rsp_ack", 64'(r_ack), 64'(ea));
    check(r_rdata == ed, "R4 rsp_rdata", 64'(r_rdata), 64'(ed));
    check(nb == eb, "R10 swclk cycle count", 64'(nb), 64'(eb));
    bad = 0;
    if (blk) begin
      // no clocks: nothing more to decode
    end else if (v.op == 1) begin
      for (int i = 0; i < 128; i++) begin
        logic e;
        if (i < 56) e = 1'b1;
        else if (i < 72) e = VEC_PAT[i - 56];
        else if (i < 124) e = 1'b1;
        else e = 1'b0;
        if (hb[i] !== e || ho[i] !== 1'b1) bad++;
      end
      check(bad == 0, "R11 switch pattern", 64'(bad), 64'd0);
    end else if (v.op >= 2) begin
      for (int i = 0; i < 8; i++) if (hb[i] !== 1'b0 || ho[i] !== 1'b1) bad++;
      check(bad == 0, "R9 flush bits low", 64'(bad), 64'd0);
    end else begin
      logic [7:0] rq;
      for (int i = 0; i < 8; i++) rq[i] = hb[i];
      check(rq == (v.req | 8'h81), "R2 request byte", 64'(rq), 64'(v.req | 8'h81));
      for (int i = 8; i < 11 + t; i++) if (ho[i] !== 1'b0) bad++;
      check(bad == 0, "R3 released for turnaround and ack", 64'(bad), 64'd0);
      if (ackok && !rd) begin
        logic [31:0] wd;
        bad = 0;
        for (int i = 11 + t; i < 11 + 2 * t; i++) if (ho[i] !== 1'b0) bad++;
        p = 11 + 2 * t;
        for (int i = 0; i < 32; i++) wd[i] = hb[p + i];
        check(bad == 0, "R5 second turnaround released", 64'(bad), 64'd0);
        check(wd == v.wdata, "R5 write data", 64'(wd), 64'(v.wdata));
        check(hb[p + 32] == ^v.wdata, "R5 write parity", 64'(hb[p + 32]), 64'(^v.wdata));
        p = p + 33;
      end else if (ackok && rd) begin
        p = 11 + t + 33;
        bad = 0;
        for (int i = 11 + t; i < p + t; i++) if (ho[i] !== 1'b0) bad++;
        check(bad == 0, "R4 released through data and turnaround", 64'(bad), 64'd0);
        p = p + t;
      end else begin
        p = eb;
      end
      if (ackok && !ep && ap) begin
        bad = 0;
        for (int i = p; i < p + int'(v.idle); i++)
          if (hb[i] !== 1'b0 || ho[i] !== 1'b1) bad++;
        check(bad == 0, "R10 idle clocks driven low", 64'(bad), 64'd0);
      end
    end
  endtask

  localparam logic [15:0] VEC_PAT = 16'hE79E;

  function automatic vec_t mk(input logic [1:0] op, input logic [7:0] req,
                              input logic [2:0] tack, input logic [31:0] trd,
                              input logic badpar);
    vec_t v;
    v = '{op, req, 32'hA5A5_0F0F, 2'd1, 8'd2, tack, trd, badpar};
    return v;
  endfunction

  initial begin
    #(20ns * 150000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(cmd_ready == 1'b1, "R12 reset cmd_ready", 64'(cmd_ready), 64'd1);
    check(rsp_valid == 1'b0, "R12 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check(swclk == 1'b0 && swdio_oe == 1'b1 && swdio_out == 1'b0,
          "R12 reset line", {61'd0, swclk, swdio_oe, swdio_out}, 64'h2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) do_vec(VECS[i], "vector table");

    // R1 half period equals cfg_clk_div+1 clocks
    cfg_clk_div = 8'd3;
    do_vec(VECS[0], "R1 divider 3");
    check(hi_w == 80.0, "R1 swclk high width ns", 64'(int'(hi_w)), 64'd80);
    cfg_clk_div = 8'd0;
    do_vec(VECS[3], "R1 divider 0");
    check(hi_w == 20.0, "R1 swclk high width ns", 64'(int'(hi_w)), 64'd20);
    cfg_clk_div = 8'd1;

    // R6 WAIT on an AP write, then R8 blocking, then R9 flush
    do_vec(mk(2'd0, 8'h0A, 3'b010, 32'h0, 1'b0), "R6 wait ack on write");
    do_vec(mk(2'd0, 8'h24, 3'b001, 32'h1111, 1'b0), "R8 blocked read");
    do_vec(mk(2'd1, 8'h00, 3'b000, 32'h0, 1'b0), "R8 blocked switch");
    do_vec(mk(2'd2, 8'h00, 3'b000, 32'h0, 1'b0), "R9 flush reports wait");
    do_vec(mk(2'd2, 8'h00, 3'b000, 32'h0, 1'b0), "R9 flush after clear");

    // R7 parity mismatch on an AP read: no idle, no data
    do_vec(mk(2'd0, 8'h87, 3'b001, 32'hCAFE0001, 1'b1), "R7 bad parity");
    do_vec(mk(2'd3, 8'h00, 3'b000, 32'h0, 1'b0), "R9 op3 flush reports parity");

    // R6 FAULT and undefined acks on reads
    do_vec(mk(2'd0, 8'h9F, 3'b100, 32'h0, 1'b0), "R6 fault ack");
    do_vec(mk(2'd2, 8'h00, 3'b000, 32'h0, 1'b0), "R9 flush reports fault");
    do_vec(mk(2'd0, 8'h24, 3'b111, 32'h0, 1'b0), "R6 undefined ack");
    do_vec(mk(2'd2, 8'h00, 3'b000, 32'h0, 1'b0), "R9 flush reports undefined");

    // R12 back-pressure on the response
    rsp_ready = 1'b0;
    run_cmd(mk(2'd0, 8'h24, 3'b001, 32'h5555AAAA, 1'b0));
    repeat (5) @(negedge clk);
    check(rsp_valid == 1'b1 && cmd_ready == 1'b0, "R12 response held",
          {62'd0, rsp_valid, cmd_ready}, 64'h2);
    check(rsp_rdata == 32'h5555AAAA, "R12 held data", 64'(rsp_rdata), 64'h5555AAAA);
    rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0 && cmd_ready == 1'b1, "R12 response taken",
          {62'd0, rsp_valid, cmd_ready}, 64'h1);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule